// File: doc/BRIEF.md
# Floating-Point Exception Status Updater

This block sits at the retirement end of a floating-point pipeline. When an operation completes, it presents its five IEEE exception flags together with the current value of the floating-point status word. The block decides whether any raised exception is enabled to trap. It then produces the new status word. It also produces exactly one of two outcomes: a trap request, or a pulse that tells the program-counter logic to step past the instruction.

The completion interface is a valid-only stream. The block has no back-pressure. It accepts a new operation on every clock in which `op_valid` is high, and it returns the result for that operation on the following clock with `res_valid` high. A producer may therefore issue operations back to back without waiting. When no operation is presented, the status output keeps its last value, and the trap and advance outputs stay low.

Top module: `fpx_status_unit`

## Requirements
- R1: Status word layout. The trap-enable mask is bits 27:23, the accrued field is bits 9:5 and the current field is bits 4:0. Within each 5-bit field the bits are, from bit 4 down to bit 0: invalid, overflow, underflow, divide-by-zero, inexact.
- R2: A trap is taken exactly when the incoming flags ANDed with the trap-enable mask give a nonzero value. The trap is reported on `trap_req`.
- R3: The current field of the result is always overwritten with the final flags. When no trap is taken, the final flags are the incoming flags unchanged. When a trap is taken, they are the reduced flags described in R4.
- R4: On a trap, the flags are first masked by the trap-enable bits. If more than one bit remains, only the highest-priority bit is kept. The priority order is invalid, then overflow, then underflow, then divide-by-zero, then inexact.
- R5: On a trap, status bit 14 is set to mark an IEEE trap type. Every status bit outside the current field, the accrued field and bit 14 passes through unchanged.
- R6: The final flags are ORed into the accrued field only when no trap is taken. On a trap, the accrued field is left unchanged.
- R7: `pc_adv` pulses when an operation completes without a trap. `pc_adv` and `trap_req` are never high together.
- R8: All outputs are registered. The result appears the cycle after `op_valid`, and `trap_req`, `pc_adv` and `res_valid` are single-cycle pulses per operation. Without `op_valid`, `stat_out` holds its value.
- R9: An operation with no exception flags clears the current field, leaves the accrued field unchanged and advances the PC.
- R10: After reset, `stat_out` is zero and `res_valid`, `trap_req` and `pc_adv` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation completes this cycle (accepted unconditionally) |
| op_flags | input | 5 | Exception flags raised by the operation |
| stat_in | input | STAT_W (32) | Current status word |
| stat_out | output | STAT_W (32) | Updated status word |
| res_valid | output | 1 | `stat_out` carries a fresh result |
| trap_req | output | 1 | IEEE trap requested for the operation |
| pc_adv | output | 1 | Advance PC to NPC and NPC by 4 |

## Verification
Priority reduction and the decision about the accrued field happen in the same cycle. When several enabled flags arrive together with flags that are not enabled, the operation traps. The current field must then hold a single bit, the highest-priority enabled one, and the accrued field must stay untouched. The bench provokes this with directed mixes of enabled and disabled flags, and then with long random runs that include back-to-back operations. A behavioural model compares the whole status word and every pulse on each clock.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W = 5;
  localparam int CUR_LO = 0;
  localparam int ACC_LO = 5;
  localparam int TT_BIT = 14;
  localparam int EN_LO  = 23;
  localparam int MIN_STAT_W = EN_LO + FLAG_W;

  typedef logic [FLAG_W-1:0] flag_vec_t;

  typedef struct packed {
    logic      trap;
    flag_vec_t final_flags;
  } decision_t;
endpackage

// File: rtl/fpx_trap_detect.sv
module fpx_trap_detect
  import fpx_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  flag_vec_t         flags,
  input  logic [STAT_W-1:0] stat,
  output logic              trap,
  output flag_vec_t         masked
);
  flag_vec_t enables;

  always_comb begin
    enables = stat[EN_LO +: FLAG_W];
    masked  = flags & enables;
    trap    = |masked;
  end
endmodule

// File: rtl/fpx_prio_pick.sv
module fpx_prio_pick #(
  parameter int W = 5
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] pick
);
  logic [W-1:0] above;

  assign above[W-1] = 1'b0;
  assign pick[W-1]  = req[W-1];

  for (genvar i = W - 2; i >= 0; i--) begin : g_chain
    assign above[i] = above[i+1] | req[i+1];
    assign pick[i]  = req[i] & ~above[i];
  end
endmodule

// File: rtl/fpx_status_merge.sv
module fpx_status_merge
  import fpx_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic [STAT_W-1:0] stat,
  input  decision_t         dec,
  output logic [STAT_W-1:0] stat_next
);
  always_comb begin
    stat_next = stat;
    stat_next[CUR_LO +: FLAG_W] = dec.final_flags;
    if (dec.trap) begin
      stat_next[TT_BIT] = 1'b1;
    end else begin
      stat_next[ACC_LO +: FLAG_W] = stat[ACC_LO +: FLAG_W] | dec.final_flags;
    end
  end
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_flags,
  input  logic [STAT_W-1:0] stat_in,
  output logic [STAT_W-1:0] stat_out,
  output logic              res_valid,
  output logic              trap_req,
  output logic              pc_adv
);
  logic              trap_c;
  flag_vec_t         masked_c;
  flag_vec_t         picked_c;
  decision_t         dec_c;
  logic [STAT_W-1:0] next_c;

  fpx_trap_detect #(.STAT_W(STAT_W)) u_detect (
    .flags  (op_flags),
    .stat   (stat_in),
    .trap   (trap_c),
    .masked (masked_c)
  );

  fpx_prio_pick #(.W(FLAG_W)) u_pick (
    .req  (masked_c),
    .pick (picked_c)
  );

  always_comb begin
    dec_c.trap        = trap_c;
    dec_c.final_flags = trap_c ? picked_c : op_flags;
  end

  fpx_status_merge #(.STAT_W(STAT_W)) u_merge (
    .stat      (stat_in),
    .dec       (dec_c),
    .stat_next (next_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_out  <= '0;
      res_valid <= 1'b0;
      trap_req  <= 1'b0;
      pc_adv    <= 1'b0;
    end else begin
      res_valid <= op_valid;
      trap_req  <= op_valid & trap_c;
      pc_adv    <= op_valid & ~trap_c;
      if (op_valid) stat_out <= next_c;
    end
  end

  assert_trap_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $countones(stat_out[CUR_LO +: FLAG_W]) == 1);

  assert_outcome_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req && pc_adv));

  assert_outcome_needs_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req || pc_adv) |-> res_valid);

  assert_result_follows_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(op_valid));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(stat_out));

  assert_trap_type_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> stat_out[TT_BIT]);

  assert_accrued_kept_on_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> stat_out[ACC_LO +: FLAG_W] == $past(stat_in[ACC_LO +: FLAG_W]));

  assert_current_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (stat_out[CUR_LO +: FLAG_W] & ~$past(op_flags)) == '0);

  assert_trap_when_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> trap_req == ((($past(op_flags)) & $past(stat_in[EN_LO +: FLAG_W])) != '0));

  initial assert (STAT_W >= MIN_STAT_W);
endmodule

// File: tb/sim_fpx_status_unit.sv
`timescale 1ns/1ps
module sim_fpx_status_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [4:0]  op_flags;
  logic [31:0] stat_in;
  logic [31:0] stat_out;
  logic        res_valid, trap_req, pc_adv;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_stat;
  logic        exp_valid, exp_trap, exp_adv;

  always #2.5 clk = ~clk;

  fpx_status_unit #(.STAT_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags(op_flags),
    .stat_in(stat_in), .stat_out(stat_out), .res_valid(res_valid),
    .trap_req(trap_req), .pc_adv(pc_adv)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Behavioural reference: integer arithmetic, priority scanned from invalid (bit 4) down
  task automatic model(input logic v, input logic [4:0] f, input logic [31:0] s);
    int en, fin, hit;
    bit tr;
    en  = int'(s[27:23]);
    fin = int'(f);
    tr  = (fin & en) != 0;
    if (tr) begin
      fin = fin & en;
      hit = 0;
      for (int b = 4; b >= 0; b--) begin
        if (hit != 0) fin = fin & ~(1 << b);
        else if (((fin >> b) & 1) != 0) hit = 1;
      end
    end
    exp_valid = v;
    exp_trap  = v && tr;
    exp_adv   = v && !tr;
    if (v) begin
      exp_stat = s;
      exp_stat[4:0] = fin[4:0];
      if (tr) exp_stat[14] = 1'b1;
      else    exp_stat[9:5] = s[9:5] | fin[4:0];
    end
  endtask

  task automatic compare_all();
    check("R3 current field", {27'd0, stat_out[4:0]}, {27'd0, exp_stat[4:0]});
    check("R6 accrued field", {27'd0, stat_out[9:5]}, {27'd0, exp_stat[9:5]});
    check("R5 other status bits", stat_out & 32'hFFFF_FC00, exp_stat & 32'hFFFF_FC00);
    check("R2 trap_req", {31'd0, trap_req}, {31'd0, exp_trap});
    check("R7 pc_adv", {31'd0, pc_adv}, {31'd0, exp_adv});
    check("R8 res_valid", {31'd0, res_valid}, {31'd0, exp_valid});
  endtask

  task automatic step(input logic v, input logic [4:0] f, input logic [31:0] s);
    op_valid = v; op_flags = f; stat_in = s;
    model(v, f, s);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_flags = '0; stat_in = '0;
    exp_stat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10 stat_out", stat_out, 32'd0);
    check("R10 pulses", {29'd0, res_valid, trap_req, pc_adv}, 32'd0);
    rst_n = 1'b1;

    // R1/R4: invalid(bit4)+overflow(bit3) both enabled, invalid wins
    step(1'b1, 5'b11000, 32'h0F80_0000);
    check("R4 invalid wins", {27'd0, stat_out[4:0]}, 32'h10);
    // R4: underflow vs divzero vs inexact, enables 2:0 only
    step(1'b1, 5'b00111, {5'b00111, 23'd0});
    check("R4 underflow wins", {27'd0, stat_out[4:0]}, 32'h04);
    // combined: enabled divzero + non-enabled overflow; accrued preset kept
    step(1'b1, 5'b01010, {5'b00010, 13'd0, 5'b10001, 5'd0});
    check("R4 R6 mixed trap", {27'd0, stat_out[9:5], stat_out[4:0]} & 32'h3FF, {22'd0, 5'b10001, 5'b00010});
    // no trap: flags not enabled, accrued ORed
    step(1'b1, 5'b00101, {5'b11010, 13'd0, 5'b01000, 5'b11111});
    check("R6 accrued or", {27'd0, stat_out[9:5]}, 32'h0D);
    // R9: zero flags clears current field and advances
    step(1'b1, 5'b00000, {5'b11111, 13'd0, 5'b00110, 5'b10101});
    check("R9 current cleared", {27'd0, stat_out[4:0]}, 32'd0);
    check("R9 advance", {31'd0, pc_adv}, 32'd1);
    // R8: idle holds
    step(1'b0, 5'b11111, 32'hFFFF_FFFF);
    step(1'b0, 5'b10000, 32'h0800_0000);
    // R5: bit 14 already set without trap stays as passed
    step(1'b1, 5'b00001, 32'h0000_4000);

    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(v, 5'($urandom), $urandom);
    end
    step(1'b0, 5'd0, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule